// File: doc/BRIEF.md
# Per-Panel Residual Bias Corrector

This block refines a model's power estimate for a set of solar panels. Each sample arrives with a strobe, a panel number, a measured power and a predicted power, all signed two's-complement integers in the same units. The block forms the residual (measured minus predicted). It moves the addressed panel's stored bias a small fixed fraction of the way toward that residual. It then returns the prediction with the rounded new bias added, together with the exact residual for a downstream anomaly stage.

Every panel has its own bias register. All biases clear to zero on reset. A single arithmetic path serves whichever panel the current sample names, so storage grows with the panel count but logic does not. The bias is held with extra fractional bits so that the slow filter keeps moving on small residuals. The filter weight is a fixed-point constant of about one hundredth, which gives the bias a memory of about a hundred samples.

Top module: `ewma_bias_corrector`

## Requirements
- R1: After reset every panel bias is zero, and `valid_o`, `err_o`, `corr_o` and `resid_o` are zero. The first sample on any panel is therefore filtered from a zero bias.
- R2: The bias is kept as a signed BIAS_W = DATA_W+FRAC_W bit value, in units of 2^-FRAC_W of a power LSB. For a valid sample the addressed panel's bias b becomes b + floor((ALPHA·(r·2^FRAC_W − b) + 2^(FRAC_W−1)) / 2^FRAC_W), where r is the residual and ALPHA = 655 at a scale of 2^16.
- R3: The updated bias saturates to the signed BIAS_W range [−2^(BIAS_W−1), 2^(BIAS_W−1)−1] and never wraps.
- R4: `corr_o` = pred + floor((b_new + 2^(FRAC_W−1)) / 2^FRAC_W), saturated to the signed DATA_W range.
- R5: While `valid_o` is high, `resid_o` equals meas − pred of that sample exactly, as a DATA_W+1 bit signed value.
- R6: A strobe with an in-range panel number gives exactly one `valid_o` pulse two clock cycles later. Strobes on consecutive cycles, including on the same panel, each give their own result, and each result includes the update made by the sample before it.
- R7: A sample changes only the bias of the panel it names. All other panels keep their bias.
- R8: A strobe whose panel number is NUM_PANELS or above changes no bias and gives no `valid_o`. It raises `err_o` for one cycle, two cycles after the strobe.
- R9: Cycles without a strobe produce neither `valid_o` nor `err_o` two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample present this cycle |
| panel_i | input | IDX_W (4) | Panel number of the sample |
| meas_i | input | DATA_W (16) | Measured power, signed |
| pred_i | input | DATA_W (16) | Predicted power, signed |
| valid_o | output | 1 | Result pulse, two cycles after an accepted strobe |
| err_o | output | 1 | Out-of-range panel pulse, two cycles after the strobe |
| corr_o | output | DATA_W (16) | Corrected prediction, signed |
| resid_o | output | DATA_W+1 (17) | Residual meas − pred, signed |

## Verification
Directed samples from reset show the first update from a zero bias and the rounding on small residuals. Back-to-back strobes on one panel and on alternating panels show that each update sees the one before it and that panels stay separate. Long runs of full-scale residuals of either sign push the bias into both saturation limits and the corrected output into its clamp, which tells saturation apart from wrapping. Random strobes mixed with idle cycles and panel numbers 13 to 15 show that bad or absent samples leave every bias untouched while the valid and error pulses stay aligned.

// File: rtl/ewma_bias_pkg.sv
package ewma_bias_pkg;
    localparam int unsigned DEF_NUM_PANELS = 13;
    localparam int unsigned DEF_DATA_W     = 16;
    localparam int unsigned DEF_FRAC_W     = 16;
    localparam int unsigned DEF_ALPHA_W    = 16;
    localparam int unsigned DEF_ALPHA      = 655;   // about 0.01 at a scale of 2^16
endpackage

// File: rtl/ewma_bias_bank.sv
module ewma_bias_bank #(
    parameter int unsigned NUM_PANELS = 13,
    parameter int unsigned BIAS_W     = 32,
    parameter int unsigned IDX_W      = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_en_i,
    input  logic [IDX_W-1:0]         wr_idx_i,
    input  logic signed [BIAS_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]         rd_idx_i,
    output logic signed [BIAS_W-1:0] rd_data_o
);
    logic signed [BIAS_W-1:0] bias_q [NUM_PANELS];

    for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                bias_q[p] <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(p))) begin
                bias_q[p] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int p = 0; p < NUM_PANELS; p++) begin
            if (rd_idx_i == IDX_W'(p)) begin
                rd_data_o = bias_q[p];
            end
        end
    end
endmodule

// File: rtl/ewma_update_dp.sv
module ewma_update_dp #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned FRAC_W  = 16,
    parameter int unsigned ALPHA_W = 16,
    parameter int unsigned ALPHA   = 655
) (
    input  logic signed [DATA_W+FRAC_W-1:0] bias_old_i,
    input  logic signed [DATA_W:0]          res_i,
    input  logic signed [DATA_W-1:0]        pred_i,
    output logic signed [DATA_W+FRAC_W-1:0] bias_new_o,
    output logic signed [DATA_W-1:0]        corr_o
);
    localparam int unsigned RES_W  = DATA_W + 1;
    localparam int unsigned BIAS_W = DATA_W + FRAC_W;
    localparam int unsigned WIDE_W = RES_W + FRAC_W + ALPHA_W + 4;

    localparam logic signed [WIDE_W-1:0] ONE_W      = 1;
    localparam logic signed [WIDE_W-1:0] HALF_W     = ONE_W <<< (FRAC_W - 1);
    localparam logic signed [WIDE_W-1:0] ALPHA_WIDE = WIDE_W'(ALPHA);
    localparam logic signed [WIDE_W-1:0] BIAS_MAX   = (ONE_W <<< (BIAS_W - 1)) - ONE_W;
    localparam logic signed [WIDE_W-1:0] BIAS_MIN   = -(ONE_W <<< (BIAS_W - 1));
    localparam logic signed [WIDE_W-1:0] DATA_MAX   = (ONE_W <<< (DATA_W - 1)) - ONE_W;
    localparam logic signed [WIDE_W-1:0] DATA_MIN   = -(ONE_W <<< (DATA_W - 1));

    logic signed [WIDE_W-1:0] res_w, bias_w, pred_w;
    logic signed [WIDE_W-1:0] diff_w, prod_w, step_w, sum_w;
    logic signed [WIDE_W-1:0] bnew_w, bint_w, csum_w;

    always_comb begin
        res_w  = {{(WIDE_W-RES_W){res_i[RES_W-1]}}, res_i};
        bias_w = {{(WIDE_W-BIAS_W){bias_old_i[BIAS_W-1]}}, bias_old_i};
        pred_w = {{(WIDE_W-DATA_W){pred_i[DATA_W-1]}}, pred_i};

        // blend toward the residual: b + alpha*(r - b), rounded half up
        diff_w = (res_w <<< FRAC_W) - bias_w;
        prod_w = diff_w * ALPHA_WIDE;
        step_w = (prod_w + HALF_W) >>> FRAC_W;
        sum_w  = bias_w + step_w;

        if (sum_w > BIAS_MAX) begin
            bnew_w = BIAS_MAX;
        end else if (sum_w < BIAS_MIN) begin
            bnew_w = BIAS_MIN;
        end else begin
            bnew_w = sum_w;
        end
        bias_new_o = bnew_w[BIAS_W-1:0];

        // add the rounded integer part of the new bias to the prediction
        bint_w = (bnew_w + HALF_W) >>> FRAC_W;
        csum_w = pred_w + bint_w;
        if (csum_w > DATA_MAX) begin
            corr_o = DATA_MAX[DATA_W-1:0];
        end else if (csum_w < DATA_MIN) begin
            corr_o = DATA_MIN[DATA_W-1:0];
        end else begin
            corr_o = csum_w[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/ewma_bias_corrector.sv
module ewma_bias_corrector
    import ewma_bias_pkg::*;
#(
    parameter int unsigned NUM_PANELS = DEF_NUM_PANELS,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned FRAC_W     = DEF_FRAC_W,
    parameter int unsigned ALPHA_W    = DEF_ALPHA_W,
    parameter int unsigned ALPHA      = DEF_ALPHA,
    localparam int unsigned IDX_W     = (NUM_PANELS > 1) ? $clog2(NUM_PANELS) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     strobe_i,
    input  logic [IDX_W-1:0]         panel_i,
    input  logic signed [DATA_W-1:0] meas_i,
    input  logic signed [DATA_W-1:0] pred_i,
    output logic                     valid_o,
    output logic                     err_o,
    output logic signed [DATA_W-1:0] corr_o,
    output logic signed [DATA_W:0]   resid_o
);
    localparam int unsigned RES_W  = DATA_W + 1;
    localparam int unsigned BIAS_W = DATA_W + FRAC_W;

    typedef struct packed {
        logic                     s1_vld;
        logic                     s1_err;
        logic [IDX_W-1:0]         s1_idx;
        logic signed [DATA_W-1:0] s1_pred;
        logic signed [RES_W-1:0]  s1_res;
        logic                     out_vld;
        logic                     out_err;
        logic signed [DATA_W-1:0] out_corr;
        logic signed [RES_W-1:0]  out_res;
    } state_t;

    state_t st_d, st_q;

    logic                     idx_ok;
    logic signed [BIAS_W-1:0] bias_rd;
    logic signed [BIAS_W-1:0] bias_new;
    logic signed [DATA_W-1:0] corr_new;

    assign idx_ok = ({1'b0, panel_i} < (IDX_W + 1)'(NUM_PANELS));

    ewma_bias_bank #(
        .NUM_PANELS (NUM_PANELS),
        .BIAS_W     (BIAS_W),
        .IDX_W      (IDX_W)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (st_q.s1_vld),
        .wr_idx_i  (st_q.s1_idx),
        .wr_data_i (bias_new),
        .rd_idx_i  (st_q.s1_idx),
        .rd_data_o (bias_rd)
    );

    ewma_update_dp #(
        .DATA_W  (DATA_W),
        .FRAC_W  (FRAC_W),
        .ALPHA_W (ALPHA_W),
        .ALPHA   (ALPHA)
    ) u_dp (
        .bias_old_i (bias_rd),
        .res_i      (st_q.s1_res),
        .pred_i     (st_q.s1_pred),
        .bias_new_o (bias_new),
        .corr_o     (corr_new)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: capture the sample and form the exact residual
        st_d.s1_vld  = strobe_i && idx_ok;
        st_d.s1_err  = strobe_i && !idx_ok;
        st_d.s1_idx  = panel_i;
        st_d.s1_pred = pred_i;
        st_d.s1_res  = {meas_i[DATA_W-1], meas_i} - {pred_i[DATA_W-1], pred_i};

        // stage 2: bank read-modify-write and result registers
        st_d.out_vld = st_q.s1_vld;
        st_d.out_err = st_q.s1_err;
        if (st_q.s1_vld) begin
            st_d.out_corr = corr_new;
            st_d.out_res  = st_q.s1_res;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.out_vld;
    assign err_o   = st_q.out_err;
    assign corr_o  = st_q.out_corr;
    assign resid_o = st_q.out_res;
endmodule

// File: rtl/ewma_bias_corrector_chk.sv
module ewma_bias_corrector_chk #(
    parameter int unsigned NUM_PANELS = 13,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned IDX_W      = 4
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     strobe_i,
    input logic [IDX_W-1:0]         panel_i,
    input logic signed [DATA_W-1:0] meas_i,
    input logic signed [DATA_W-1:0] pred_i,
    input logic                     valid_o,
    input logic                     err_o,
    input logic signed [DATA_W:0]   resid_o
);
    logic in_range;
    assign in_range = ({1'b0, panel_i} < (IDX_W + 1)'(NUM_PANELS));

    p_valid_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && in_range) |-> ##2 valid_o);

    p_bad_index_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !in_range) |-> ##2 (err_o && !valid_o));

    p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |-> ##2 (!valid_o && !err_o));

    p_resid_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (resid_o == ($past({meas_i[DATA_W-1], meas_i}, 2)
                               - $past({pred_i[DATA_W-1], pred_i}, 2))));

    p_pulse_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({valid_o, err_o}));
endmodule

bind ewma_bias_corrector ewma_bias_corrector_chk #(
    .NUM_PANELS (NUM_PANELS),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .panel_i  (panel_i),
    .meas_i   (meas_i),
    .pred_i   (pred_i),
    .valid_o  (valid_o),
    .err_o    (err_o),
    .resid_o  (resid_o)
);

// File: tb/ewma_bias_corrector_bench.sv
module ewma_bias_corrector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 13;

    logic               clk_i = 1'b0;
    logic               rst_ni = 1'b0;
    logic               strobe_i = 1'b0;
    logic [3:0]         panel_i = '0;
    logic signed [15:0] meas_i = '0;
    logic signed [15:0] pred_i = '0;
    logic               valid_o, err_o;
    logic signed [15:0] corr_o;
    logic signed [16:0] resid_o;

    int checks = 0;
    int errors = 0;

    longint bias_m [NP];
    bit     e_have [2];
    bit     e_vld  [2];
    bit     e_err  [2];
    longint e_corr [2];
    longint e_res  [2];
    string  e_tag  [2];
    string  e_vtag [2];

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    ewma_bias_corrector u_ewma_bias_corrector (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe_i),
        .panel_i  (panel_i),
        .meas_i   (meas_i),
        .pred_i   (pred_i),
        .valid_o  (valid_o),
        .err_o    (err_o),
        .corr_o   (corr_o),
        .resid_o  (resid_o)
    );

    function automatic longint clamp(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint next_bias(longint b, longint r);
        longint step;
        step = (((r * 65536) - b) * 655 + 32768) >>> 16;
        return clamp(b + step, -(64'sd1 <<< 31), (64'sd1 <<< 31) - 1);
    endfunction

    function automatic longint corrected(longint pred, longint b);
        return clamp(pred + ((b + 32768) >>> 16), -32768, 32767);
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit stb, int idx, int meas, int pred, string tag);
        longint r, nb;
        @(negedge clk_i);
        if (e_have[1]) begin
            check(e_vtag[1], "valid_o", longint'(valid_o), longint'(e_vld[1]));
            check("R8", "err_o", longint'(err_o), longint'(e_err[1]));
            if (e_vld[1]) begin
                check(e_tag[1], "corr_o", longint'(corr_o), e_corr[1]);
                check("R5", "resid_o", longint'(resid_o), e_res[1]);
            end
        end
        strobe_i = stb;
        panel_i  = 4'(idx);
        meas_i   = 16'(meas);
        pred_i   = 16'(pred);
        e_have[1] = e_have[0]; e_vld[1] = e_vld[0]; e_err[1] = e_err[0];
        e_corr[1] = e_corr[0]; e_res[1] = e_res[0];
        e_tag[1]  = e_tag[0];  e_vtag[1] = e_vtag[0];
        e_have[0] = 1'b1;
        e_vld[0]  = stb && (idx < NP);
        e_err[0]  = stb && (idx >= NP);
        e_tag[0]  = tag;
        e_vtag[0] = !stb ? "R9" : ((idx >= NP) ? "R8" : "R6");
        e_corr[0] = 0;
        e_res[0]  = 0;
        if (stb && idx < NP) begin
            r = longint'(meas) - longint'(pred);
            nb = next_bias(bias_m[idx], r);
            bias_m[idx] = nb;
            e_corr[0] = corrected(longint'(pred), nb);
            e_res[0]  = r;
        end
    endtask

    initial begin
        for (int p = 0; p < NP; p++) bias_m[p] = 0;
        for (int k = 0; k < 2; k++) e_have[k] = 1'b0;
        void'($urandom(32'd2024));

        repeat (3) @(posedge clk_i);
        #1;
        check("R1", "valid_o in reset", longint'(valid_o), 0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", "valid_o after reset", longint'(valid_o), 0);
        check("R1", "err_o after reset", longint'(err_o), 0);
        check("R1", "corr_o after reset", longint'(corr_o), 0);
        check("R1", "resid_o after reset", longint'(resid_o), 0);

        // first samples from a zero bias, including small residuals for rounding
        step(1, 0, 1000, 0, "R1");
        step(1, 1, 1, 0, "R2");
        step(1, 2, -1, 0, "R2");
        step(0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");
        // out-of-range panel numbers, then confirm panel 12 is still from zero
        step(1, 13, 30000, -30000, "R8");
        step(1, 15, -30000, 30000, "R8");
        step(1, 12, 500, 200, "R8");
        // back-to-back on one panel, then alternating panels
        for (int i = 0; i < 6; i++) step(1, 3, 4000, 1000, "R6");
        for (int i = 0; i < 10; i++) step(1, 4 + (i % 2), (i % 2) ? 3000 : -3000, 0, "R7");

        // random mix of idle cycles, bad panels and samples
        for (int i = 0; i < 3000; i++) begin
            int s, idx, m, pr;
            s   = (($urandom % 10) < 7) ? 1 : 0;
            idx = int'($urandom % 16);
            m   = int'($urandom % 65536) - 32768;
            pr  = int'($urandom % 65536) - 32768;
            step(s[0], idx, m, pr, "R2");
        end

        // drive both bias limits with full-scale residuals
        for (int i = 0; i < 300; i++) step(1, 6, 32767, -32768, "R3");
        step(1, 6, 32767, 32767, "R4");
        for (int i = 0; i < 300; i++) step(1, 7, -32768, 32767, "R3");
        step(1, 7, -32768, -32768, "R4");
        step(1, 8, 0, 0, "R7");
        step(0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule